// File: doc/BRIEF.md
# PWM Output Override Unit

This block stands between a multi-channel PWM generator and the gate-drive pins of a three-phase inverter for a brushless DC motor. For every pin it picks one of two sources: the raw PWM waveform from the duty-cycle comparators, or a static level held in a register. One active register chooses the source for each pin, and a second active register holds the static levels. The duty cycle therefore sets the average load voltage, and the override settings decide which phases conduct.

A six-entry commutation table holds one source-select byte and one static-level byte for each step. A rotor-position strobe copies the entry at the current step index into both active registers on a single clock edge, so every pin switches together, and the index then moves to the next step, wrapping from the last step back to the first. A complementary mode forces each even pin to be the inverse of its odd partner. A parameter sets whether "active" means a high pin or a low pin. Software loads all registers and table entries through a synchronous write port. The pin outputs are registered.

Top module: `pwm_override_unit`

## Requirements
- R1: While `rst_n` is low, the select register becomes all ones, the level register all zeros, the table selects all ones, the table levels all zeros, and the step index 0, and every pin is inactive. After reset, every pin follows its `pwm_in` bit.
- R2: A pin whose select bit is 1 drives its `pwm_in` bit, mapped through the active polarity.
- R3: A pin whose select bit is 0 drives its level bit: 1 gives the active level and 0 gives the inactive level.
- R4: While `compl_en` is 1, pins 0, 2 and 4 each carry the inverse of the logical level of pins 1, 3 and 5 respectively, whatever the even pin's own select or level bits hold. Pins 6 and 7 are not affected.
- R5: With `ACTIVE_HIGH` = 1 an active pin is driven high. With `ACTIVE_HIGH` = 0 an active pin is driven low, and the reset level of every pin is high.
- R6: Write address map: 0 is the active select register and 1 is the active level register. 16+k is the table select byte of step k and 24+k is the table level byte of step k, for k = 0..5. A write to any other address changes nothing.
- R7: On a clock edge with `pos_strobe` high, the table entry at the current step index is loaded into both active registers, and the index advances by one, going from 5 to 0.
- R8: When a strobe and a write to address 0 or 1 fall on the same edge, the table entry is loaded and the write is dropped.
- R9: The pins are registered. A register write or strobe at edge k shows on the pins after edge k+1 and not before.
- R10: Without a strobe, the step index keeps its value, including while table entries are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | 5 | Write address |
| wr_data | input | NPINS | Write data, one bit per pin |
| pos_strobe | input | 1 | Rotor-position event: step the commutation table |
| compl_en | input | 1 | Complementary pairing of even pins to odd pins |
| pwm_in | input | NPINS | Raw PWM waveforms from the comparators |
| pwm_pin | output | NPINS | Registered drive to the inverter pins |
| step_idx | output | $clog2(NSTEPS) | Current commutation step |

## Verification
The bound checker checks on every cycle that the step index stays below six, advances with wrap on a strobe and holds without one, that a strobe lands the addressed table entry in the active registers, that reset leaves the pins idle, and that each complementary pair differs while pairing is on. The per-pin source selection, the polarity mapping, the address decode with its ignored addresses, the priority of a strobe over a direct write, and the one-clock output latency are shown only by the bench. It sweeps all 256 select patterns against several level, PWM and pairing combinations on both polarities, and then walks the table through more than two full turns.

// File: rtl/pwm_ovr_pkg.sv
// Package: shared address map and constants for the PWM output override unit.
// Assumes: a 5-bit write address; table slots are grouped in spans of eight.
package pwm_ovr_pkg;

    localparam int ADDR_W   = 5;
    localparam int TBL_SPAN = 8;

    localparam logic [ADDR_W-1:0] A_SEL       = 5'd0;
    localparam logic [ADDR_W-1:0] A_LVL       = 5'd1;
    localparam logic [ADDR_W-1:0] A_TBL_SEL   = 5'd16;
    localparam logic [ADDR_W-1:0] A_TBL_LVL   = 5'd24;

    // Decoded target of a write to the active registers.
    typedef enum logic [1:0] {
        WR_NONE = 2'd0,
        WR_SEL  = 2'd1,
        WR_LVL  = 2'd2
    } act_wr_e;

endpackage

// File: rtl/pwm_ovr_table.sv
// Module: commutation table and step counter.
// Holds NSTEPS pairs of (select, level) bytes, written through the register
// port, and presents the entry at the current step combinationally.
// Assumes: NSTEPS <= TBL_SPAN; strobe reads the entry before any same-edge write.
module pwm_ovr_table
    import pwm_ovr_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int NSTEPS = 6,
    parameter int SW     = $clog2(NSTEPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NPINS-1:0]  wr_data,
    input  logic              strobe,
    output logic [SW-1:0]     step,
    output logic [NPINS-1:0]  ent_sel,
    output logic [NPINS-1:0]  ent_lvl
);

    localparam logic [SW-1:0] LAST_STEP = SW'(NSTEPS - 1);

    logic [NPINS-1:0] sel_mem [NSTEPS];
    logic [NPINS-1:0] lvl_mem [NSTEPS];

    genvar k;
    generate
        for (k = 0; k < NSTEPS; k++) begin : g_slot
            localparam logic [ADDR_W-1:0] SEL_ADDR = A_TBL_SEL + ADDR_W'(k);
            localparam logic [ADDR_W-1:0] LVL_ADDR = A_TBL_LVL + ADDR_W'(k);

            // Store one step's select and level bytes.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sel_mem[k] <= '1;
                    lvl_mem[k] <= '0;
                end else if (wr_en) begin
                    if (wr_addr == SEL_ADDR) sel_mem[k] <= wr_data;
                    if (wr_addr == LVL_ADDR) lvl_mem[k] <= wr_data;
                end
            end
        end
    endgenerate

    // Advance the step index on each position strobe, wrapping at the last step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step <= '0;
        end else if (strobe) begin
            step <= (step == LAST_STEP) ? '0 : step + 1'b1;
        end
    end

    // Present the entry at the current step.
    always_comb begin
        ent_sel = sel_mem[step];
        ent_lvl = lvl_mem[step];
    end

endmodule

// File: rtl/pwm_ovr_regs.sv
// Module: active select and level registers.
// Loaded either by a direct write or, with priority, by a table step.
// Assumes: strobe and a direct write on the same edge resolve to the table entry.
module pwm_ovr_regs
    import pwm_ovr_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NPINS-1:0]  wr_data,
    input  logic              strobe,
    input  logic [NPINS-1:0]  ent_sel,
    input  logic [NPINS-1:0]  ent_lvl,
    output logic [NPINS-1:0]  act_sel,
    output logic [NPINS-1:0]  act_lvl
);

    act_wr_e wr_kind;

    // Decode which active register a write targets.
    always_comb begin
        wr_kind = WR_NONE;
        if (wr_en) begin
            if (wr_addr == A_SEL)      wr_kind = WR_SEL;
            else if (wr_addr == A_LVL) wr_kind = WR_LVL;
        end
    end

    // Update the active registers: reset, table step, then direct write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_sel <= '1;
            act_lvl <= '0;
        end else if (strobe) begin
            act_sel <= ent_sel;
            act_lvl <= ent_lvl;
        end else begin
            case (wr_kind)
                WR_SEL:  act_sel <= wr_data;
                WR_LVL:  act_lvl <= wr_data;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pwm_ovr_mux.sv
// Module: per-pin source selection, complementary pairing, polarity and the
// output register.
// Assumes: 2*NPAIRS <= NPINS; pairs are (0,1), (2,3), ... with the odd pin leading.
module pwm_ovr_mux #(
    parameter int NPINS       = 8,
    parameter int NPAIRS      = 3,
    parameter bit ACTIVE_HIGH = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] act_sel,
    input  logic [NPINS-1:0] act_lvl,
    input  logic [NPINS-1:0] pwm_in,
    input  logic             compl_en,
    output logic [NPINS-1:0] pin_q
);

    localparam logic [NPINS-1:0] IDLE = ACTIVE_HIGH ? '0 : '1;

    logic [NPINS-1:0] src;
    logic [NPINS-1:0] lvl;
    logic [NPINS-1:0] pin_d;

    genvar i;
    generate
        for (i = 0; i < NPINS; i++) begin : g_pin
            // Pick the PWM waveform or the static level for this pin.
            assign src[i] = act_sel[i] ? pwm_in[i] : act_lvl[i];

            if ((i % 2 == 0) && (i < 2 * NPAIRS)) begin : g_even
                // Even pin of a pair: follows the inverse of its odd partner when paired.
                assign lvl[i] = compl_en ? ~src[i+1] : src[i];
            end else begin : g_plain
                assign lvl[i] = src[i];
            end
        end
    endgenerate

    // Map the logical level onto the pin polarity.
    always_comb begin
        pin_d = ACTIVE_HIGH ? lvl : ~lvl;
    end

    // Register the pins; idle during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= IDLE;
        else        pin_q <= pin_d;
    end

endmodule

// File: rtl/pwm_override_unit.sv
// Module: top of the PWM output override unit.
// Ties together the commutation table, the active override registers and
// the per-pin output stage.
// Assumes: NSTEPS <= 8, 2*NPAIRS <= NPINS, inputs synchronous to clk.
module pwm_override_unit
    import pwm_ovr_pkg::*;
#(
    parameter int NPINS       = 8,
    parameter int NSTEPS      = 6,
    parameter int NPAIRS      = 3,
    parameter bit ACTIVE_HIGH = 1'b1,
    localparam int SW         = $clog2(NSTEPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NPINS-1:0]  wr_data,
    input  logic              pos_strobe,
    input  logic              compl_en,
    input  logic [NPINS-1:0]  pwm_in,
    output logic [NPINS-1:0]  pwm_pin,
    output logic [SW-1:0]     step_idx
);

    logic [NPINS-1:0] ent_sel;
    logic [NPINS-1:0] ent_lvl;
    logic [NPINS-1:0] act_sel;
    logic [NPINS-1:0] act_lvl;

    pwm_ovr_table #(
        .NPINS (NPINS),
        .NSTEPS(NSTEPS),
        .SW    (SW)
    ) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .strobe (pos_strobe),
        .step   (step_idx),
        .ent_sel(ent_sel),
        .ent_lvl(ent_lvl)
    );

    pwm_ovr_regs #(
        .NPINS(NPINS)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .strobe (pos_strobe),
        .ent_sel(ent_sel),
        .ent_lvl(ent_lvl),
        .act_sel(act_sel),
        .act_lvl(act_lvl)
    );

    pwm_ovr_mux #(
        .NPINS      (NPINS),
        .NPAIRS     (NPAIRS),
        .ACTIVE_HIGH(ACTIVE_HIGH)
    ) u_mux (
        .clk     (clk),
        .rst_n   (rst_n),
        .act_sel (act_sel),
        .act_lvl (act_lvl),
        .pwm_in  (pwm_in),
        .compl_en(compl_en),
        .pin_q   (pwm_pin)
    );

endmodule

// File: rtl/pwm_override_unit_chk.sv
// Module: property checker for the PWM output override unit, bound to the top.
// Assumes: the same parameters as the instance it is bound to.
module pwm_override_unit_chk #(
    parameter int NPINS       = 8,
    parameter int NSTEPS      = 6,
    parameter int NPAIRS      = 3,
    parameter bit ACTIVE_HIGH = 1'b1,
    parameter int SW          = $clog2(NSTEPS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pos_strobe,
    input logic             compl_en,
    input logic [NPINS-1:0] pwm_pin,
    input logic [SW-1:0]    step_idx,
    input logic [NPINS-1:0] ent_sel,
    input logic [NPINS-1:0] ent_lvl,
    input logic [NPINS-1:0] act_sel,
    input logic [NPINS-1:0] act_lvl
);

    localparam logic [NPINS-1:0] IDLE = ACTIVE_HIGH ? '0 : '1;

    function automatic logic [SW-1:0] next_step(input logic [SW-1:0] s);
        return (s == SW'(NSTEPS - 1)) ? '0 : s + 1'b1;
    endfunction

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (pwm_pin == IDLE));

    assert_step_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        step_idx < SW'(NSTEPS));

    assert_step_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pos_strobe |=> (step_idx == next_step($past(step_idx))));

    assert_strobe_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pos_strobe |=> (act_sel == $past(ent_sel)) && (act_lvl == $past(ent_lvl)));

    assert_step_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !pos_strobe |=> $stable(step_idx));

    genvar p;
    generate
        for (p = 0; p < NPAIRS; p++) begin : g_pair
            assert_pair_opposite_R4: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(compl_en)) |-> (pwm_pin[2*p] != pwm_pin[2*p+1]));
        end
    endgenerate

endmodule

bind pwm_override_unit pwm_override_unit_chk #(
    .NPINS      (NPINS),
    .NSTEPS     (NSTEPS),
    .NPAIRS     (NPAIRS),
    .ACTIVE_HIGH(ACTIVE_HIGH),
    .SW         (SW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pos_strobe(pos_strobe),
    .compl_en  (compl_en),
    .pwm_pin   (pwm_pin),
    .step_idx  (step_idx),
    .ent_sel   (ent_sel),
    .ent_lvl   (ent_lvl),
    .act_sel   (act_sel),
    .act_lvl   (act_lvl)
);

// File: tb/pwm_override_unit_tb.sv
// Bench: sweeps select patterns against level, PWM and pairing inputs on both
// polarities, then walks the commutation table; expected pins come from a
// bench-side model of the requirements.
module pwm_override_unit_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       pos_strobe = 1'b0;
    logic       compl_en = 1'b0;
    logic [7:0] pwm_in = 8'hA5;
    logic [7:0] pin_hi;
    logic [7:0] pin_lo;
    logic [2:0] step_hi;
    logic [2:0] step_lo;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    logic [7:0] tsel [6];
    logic [7:0] tlvl [6];

    always #10 clk = ~clk;

    pwm_override_unit #(.ACTIVE_HIGH(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pos_strobe(pos_strobe), .compl_en(compl_en),
        .pwm_in(pwm_in), .pwm_pin(pin_hi), .step_idx(step_hi)
    );

    pwm_override_unit #(.ACTIVE_HIGH(1'b0)) u_dut_lo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pos_strobe(pos_strobe), .compl_en(compl_en),
        .pwm_in(pwm_in), .pwm_pin(pin_lo), .step_idx(step_lo)
    );

    function automatic logic [7:0] model(input logic [7:0] s, input logic [7:0] l,
                                         input logic [7:0] p, input logic cm);
        logic [7:0] v;
        for (int i = 0; i < 8; i++) v[i] = s[i] ? p[i] : l[i];
        if (cm) for (int q = 0; q < 3; q++) v[2*q] = ~v[2*q+1];
        return v;
    endfunction

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic both(input logic [7:0] lvl, input string req);
        check(pin_hi, lvl, req);
        check(pin_lo, ~lvl, req);
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic strobe_once();
        pos_strobe = 1'b1;
        @(negedge clk);
        pos_strobe = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] lv [4];
        logic [7:0] pv [4];
        lv[0] = 8'h00; lv[1] = 8'hFF; lv[2] = 8'h5A; lv[3] = 8'hC3;
        pv[0] = 8'h00; pv[1] = 8'hFF; pv[2] = 8'h96; pv[3] = 8'h3C;

        // R1 / R5: idle pins and step 0 during reset
        repeat (3) @(negedge clk);
        check(pin_hi, 8'h00, "R1");
        check(pin_lo, 8'hFF, "R5");
        check({5'd0, step_hi}, 8'd0, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        // R1: after reset every pin follows the PWM input
        both(8'hA5, "R1");

        // R2 R3 R4 R5: sweep all select patterns
        for (int s = 0; s < 256; s++) begin
            wr(5'd0, 8'(s));
            for (int l = 0; l < 4; l++) begin
                wr(5'd1, lv[l]);
                for (int cm = 0; cm < 2; cm++) begin
                    compl_en = cm[0];
                    for (int p = 0; p < 4; p++) begin
                        pwm_in = pv[p];
                        @(negedge clk);
                        both(model(8'(s), lv[l], pv[p], cm[0]), "R2 R3 R4 R5");
                    end
                end
            end
        end
        compl_en = 1'b0;

        // R9: latency of one clock after the write edge
        wr(5'd1, 8'hFF);
        wr(5'd0, 8'hFF);
        pwm_in = 8'h00;
        @(negedge clk);
        both(8'h00, "R9");
        wr(5'd0, 8'h00);
        both(8'h00, "R9");
        @(negedge clk);
        both(8'hFF, "R9");

        // R6: unmapped addresses change nothing
        wr(5'd1, 8'h0F);
        @(negedge clk);
        both(8'h0F, "R6");
        wr(5'd2, 8'hFF);
        wr(5'd22, 8'hFF);
        wr(5'd23, 8'hFF);
        wr(5'd30, 8'hFF);
        wr(5'd31, 8'hFF);
        wr(5'd15, 8'hFF);
        @(negedge clk);
        both(8'h0F, "R6");

        // R6 R10: load the table; step index must hold
        for (int k = 0; k < 6; k++) begin
            tsel[k] = 8'h11 << (k % 4);
            tlvl[k] = (8'h01 << k) | (8'h01 << ((k + 3) % 6)) | 8'h80;
            wr(5'(16 + k), tsel[k]);
            wr(5'(24 + k), tlvl[k]);
        end
        check({5'd0, step_hi}, 8'd0, "R10");
        check({5'd0, step_lo}, 8'd0, "R10");

        // R7: walk the table more than twice around
        pwm_in = 8'hAA;
        for (int n = 0; n < 14; n++) begin
            strobe_once();
            check({5'd0, step_hi}, 8'((n + 1) % 6), "R7");
            @(negedge clk);
            both(model(tsel[n % 6], tlvl[n % 6], 8'hAA, 1'b0), "R7");
        end

        // R8: strobe wins over a same-edge direct write
        pos_strobe = 1'b1;
        wr_en = 1'b1; wr_addr = 5'd0; wr_data = 8'h00;
        @(negedge clk);
        pos_strobe = 1'b0; wr_en = 1'b0;
        check({5'd0, step_hi}, 8'd3, "R8");
        @(negedge clk);
        both(model(tsel[2], tlvl[2], 8'hAA, 1'b0), "R8");
        pos_strobe = 1'b1;
        wr_en = 1'b1; wr_addr = 5'd1; wr_data = 8'h00;
        @(negedge clk);
        pos_strobe = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        both(model(tsel[3], tlvl[3], 8'hAA, 1'b0), "R8");

        // R10: idle cycles keep the step index
        repeat (5) @(negedge clk);
        check({5'd0, step_hi}, 8'd4, "R10");
        check({5'd0, step_lo}, 8'd4, "R10");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule